// File: doc/BRIEF.md
# Predication Table Expander

This block holds a small key-value table that says which destination registers are predicated. Each table entry names one destination register, states whether that register lives in the integer or the floating-point register file, and names an integer register whose bits act as the per-element predicate. The block turns this table around into two per-register state arrays, one for each register file. An instruction decoder can then find the predication state for its destination with a single indexed lookup, with no search through the table.

A lookup is given a destination index and a register-file select. It returns whether that destination is predicated and, if so, its zeroing flag, its invert flag and the index of the predicate register. The caller reads that integer register and presents its contents back on `pred_reg`. The block then forms the final element-enable mask and a mask of the elements that must be written with zero. The register file and the execution units are outside the block.

Top module: `pred_table_expander`

## Requirements
- R1: After reset no destination of either register file is enabled: `lk_enabled` is 0, `elem_mask` is all ones and `zero_mask` is all zeros for every lookup.
- R2: A write with `wr_en` high stores `wr_data` into entry `wr_addr` and marks the entry valid. The fields are: bit 12 zeroing flag, bit 11 invert flag, bit 10 register file (0 = integer, 1 = floating-point), bits 9:5 destination index, bits 4:0 predicate register index.
- R3: A lookup of (`lk_fp`, `lk_dst`) that matches the file and destination of a valid entry returns `lk_enabled`=1 with that entry's zeroing flag, invert flag and predicate index. The same destination index in the other register file is not affected.
- R4: A lookup of a destination that is not enabled gives an all-ones `elem_mask` and a zero `zero_mask`, and `lk_zero`, `lk_inv` and `lk_pidx` read as 0.
- R5: For an enabled destination with the invert flag clear, `elem_mask` equals `pred_reg`. Element i is active when bit i is 1.
- R6: For an enabled destination with the invert flag set, `elem_mask` is the bitwise complement of `pred_reg`.
- R7: `zero_mask` bit i is 1 exactly when the destination is enabled, its zeroing flag is set and `elem_mask` bit i is 0.
- R8: When several valid entries name the same file and destination, the entry with the highest index supplies the state.
- R9: A write is visible to lookups from the cycle after its clock edge. Overwriting an entry with a different destination releases the old slot, unless another valid entry still names it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It clears the table. |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Table entry to write |
| wr_data | input | 13 | Entry value, using the field layout of R2 |
| lk_dst | input | 5 | Destination register index to look up |
| lk_fp | input | 1 | Register file of the lookup (1 = floating-point) |
| pred_reg | input | 64 | Contents of the integer register named by `lk_pidx` |
| lk_enabled | output | 1 | The destination is predicated |
| lk_zero | output | 1 | Masked-off elements are zeroed |
| lk_inv | output | 1 | The predicate is inverted |
| lk_pidx | output | 5 | Index of the predicate register |
| elem_mask | output | 64 | Per-element enable |
| zero_mask | output | 64 | Elements that receive zero |

## Verification
The directed cases first cover the empty table after reset. They then place one integer entry and one floating-point entry on the same destination index, which shows whether the file select keeps the two arrays apart. They also combine the invert and zeroing flags, which separates the plain mask from the complemented mask and from the zero mask. Several entries aimed at one slot, followed by one of them being moved to another destination, show whether priority goes to the highest index and whether a slot is released once no entry names it. A long random run then writes entries whose destinations are mostly drawn from a narrow range, to force collisions, and looks up random slots with random predicate values. Each result is compared with a reference that searches the table directly.

// File: rtl/pte_pkg.sv
`timescale 1ns/1ps
package pte_pkg;
   parameter int REG_IDX_W = 5;
   localparam int NUM_REGS = 1 << REG_IDX_W;

   // One stored table entry (field order fixes the write-data layout)
   typedef struct packed {
      logic                 zero;
      logic                 inv;
      logic                 fp;
      logic [REG_IDX_W-1:0] dst;
      logic [REG_IDX_W-1:0] pidx;
   } pte_entry_t;

   // Expanded per-register predication state
   typedef struct packed {
      logic                 en;
      logic                 zero;
      logic                 inv;
      logic [REG_IDX_W-1:0] pidx;
   } pte_slot_t;

   localparam int ENTRY_W = $bits(pte_entry_t);
endpackage

// File: rtl/pte_table.sv
`timescale 1ns/1ps
module pte_table
   import pte_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   localparam int AW = $clog2(NUM_ENTRIES)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [AW-1:0]                      wr_addr,
   input  pte_entry_t                         wr_data,
   output pte_entry_t [NUM_ENTRIES-1:0]       ent_q,
   output logic       [NUM_ENTRIES-1:0]       vld_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_q <= '0;
         vld_q <= '0;
      end else if (wr_en) begin
         ent_q[wr_addr] <= wr_data;
         vld_q[wr_addr] <= 1'b1;
      end
   end

   // R2: a write lands in the addressed entry and validates it
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (vld_q[$past(wr_addr)] && ent_q[$past(wr_addr)] == $past(wr_data)));

   // R2: entries without a write keep their value
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ent_q) && $stable(vld_q));

endmodule

// File: rtl/pte_expand.sv
`timescale 1ns/1ps
module pte_expand
   import pte_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter bit PRIO_HIGH   = 1'b1
) (
   input  pte_entry_t [NUM_ENTRIES-1:0] ent,
   input  logic       [NUM_ENTRIES-1:0] vld,
   output pte_slot_t                    int_slot [NUM_REGS],
   output pte_slot_t                    fp_slot  [NUM_REGS]
);

   for (genvar s = 0; s < NUM_REGS; s++) begin : g_slot
      if (PRIO_HIGH) begin : g_hi
         // ascending scan: later (higher) entries overwrite earlier ones
         always_comb begin
            int_slot[s] = '0;
            fp_slot[s]  = '0;
            for (int e = 0; e < NUM_ENTRIES; e++) begin
               if (vld[e] && ent[e].dst == REG_IDX_W'(s)) begin
                  if (ent[e].fp) fp_slot[s]  = '{1'b1, ent[e].zero, ent[e].inv, ent[e].pidx};
                  else           int_slot[s] = '{1'b1, ent[e].zero, ent[e].inv, ent[e].pidx};
               end
            end
         end
      end else begin : g_lo
         // descending scan: lower entries win
         always_comb begin
            int_slot[s] = '0;
            fp_slot[s]  = '0;
            for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
               if (vld[e] && ent[e].dst == REG_IDX_W'(s)) begin
                  if (ent[e].fp) fp_slot[s]  = '{1'b1, ent[e].zero, ent[e].inv, ent[e].pidx};
                  else           int_slot[s] = '{1'b1, ent[e].zero, ent[e].inv, ent[e].pidx};
               end
            end
         end
      end
   end

endmodule

// File: rtl/pte_mask.sv
`timescale 1ns/1ps
module pte_mask
   import pte_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pte_slot_t        slot,
   input  logic [XLEN-1:0]  pred_reg,
   output logic [XLEN-1:0]  elem_mask,
   output logic [XLEN-1:0]  zero_mask
);

   logic [XLEN-1:0] raw_mask;

   always_comb begin
      raw_mask  = slot.inv ? ~pred_reg : pred_reg;
      elem_mask = slot.en ? raw_mask : {XLEN{1'b1}};
      zero_mask = (slot.en && slot.zero) ? ~elem_mask : '0;
   end

   // R4: an unpredicated destination runs every element and zeroes none
   a_r4_open_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !slot.en |-> (&elem_mask) && (zero_mask == '0));

   // R6: the inverted predicate and the raw predicate share no set bit
   a_r6_inverted: assert property (@(posedge clk) disable iff (!rst_n)
      (slot.en && slot.inv) |-> ((elem_mask & pred_reg) == '0));

   // R7: no element is both active and zeroed
   a_r7_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_mask & elem_mask) == '0);

   // R7: zeroing only comes from a predicated slot with its zero flag set
   a_r7_zero_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (|zero_mask) |-> (slot.en && slot.zero));

endmodule

// File: rtl/pred_table_expander.sv
`timescale 1ns/1ps
module pred_table_expander
   import pte_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int XLEN        = 64,
   parameter bit PRIO_HIGH   = 1'b1,
   localparam int AW         = $clog2(NUM_ENTRIES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [AW-1:0]         wr_addr,
   input  logic [ENTRY_W-1:0]    wr_data,
   input  logic [REG_IDX_W-1:0]  lk_dst,
   input  logic                  lk_fp,
   input  logic [XLEN-1:0]       pred_reg,
   output logic                  lk_enabled,
   output logic                  lk_zero,
   output logic                  lk_inv,
   output logic [REG_IDX_W-1:0]  lk_pidx,
   output logic [XLEN-1:0]       elem_mask,
   output logic [XLEN-1:0]       zero_mask
);

   if (NUM_ENTRIES < 2 || (1 << AW) != NUM_ENTRIES) begin : g_bad_entries
      $error("NUM_ENTRIES must be a power of two of at least 2");
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("XLEN must be positive");
   end

   pte_entry_t [NUM_ENTRIES-1:0] ent_q;
   logic       [NUM_ENTRIES-1:0] vld_q;
   pte_slot_t                    int_slot [NUM_REGS];
   pte_slot_t                    fp_slot  [NUM_REGS];
   pte_slot_t                    sel;

   pte_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (pte_entry_t'(wr_data)),
      .ent_q   (ent_q),
      .vld_q   (vld_q)
   );

   pte_expand #(.NUM_ENTRIES(NUM_ENTRIES), .PRIO_HIGH(PRIO_HIGH)) u_expand (
      .ent      (ent_q),
      .vld      (vld_q),
      .int_slot (int_slot),
      .fp_slot  (fp_slot)
   );

   always_comb sel = lk_fp ? fp_slot[lk_dst] : int_slot[lk_dst];

   pte_mask #(.XLEN(XLEN)) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot      (sel),
      .pred_reg  (pred_reg),
      .elem_mask (elem_mask),
      .zero_mask (zero_mask)
   );

   assign lk_enabled = sel.en;
   assign lk_zero    = sel.zero;
   assign lk_inv     = sel.inv;
   assign lk_pidx    = sel.pidx;

   // Direct table search used only to cross-check the expanded state
   logic backed;
   always_comb begin
      backed = 1'b0;
      for (int e = 0; e < NUM_ENTRIES; e++)
         if (vld_q[e] && ent_q[e].fp == lk_fp && ent_q[e].dst == lk_dst) backed = 1'b1;
   end

   // R3: an enabled slot is always named by some valid entry of that file
   a_r3_slot_backed: assert property (@(posedge clk) disable iff (!rst_n)
      lk_enabled |-> backed);

   // R3: a slot named by a valid entry is always enabled
   a_r3_entry_enables: assert property (@(posedge clk) disable iff (!rst_n)
      backed |-> lk_enabled);

   // R1: straight after reset release the table is empty
   a_r1_empty_after_reset: assert property (@(posedge clk)
      (!rst_n) |=> (vld_q == '0));

endmodule

// File: tb/sim_pred_table_expander.sv
`timescale 1ns/1ps
module sim_pred_table_expander;
   localparam int NE = 16;
   localparam int XL = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [12:0]   wr_data = '0;
   logic [4:0]    lk_dst = '0;
   logic          lk_fp = 1'b0;
   logic [XL-1:0] pred_reg = '0;
   logic          lk_enabled, lk_zero, lk_inv;
   logic [4:0]    lk_pidx;
   logic [XL-1:0] elem_mask, zero_mask;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic        ref_v [NE];
   logic [12:0] ref_d [NE];

   always #5 clk = ~clk;

   pred_table_expander u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .lk_dst(lk_dst), .lk_fp(lk_fp), .pred_reg(pred_reg),
      .lk_enabled(lk_enabled), .lk_zero(lk_zero), .lk_inv(lk_inv), .lk_pidx(lk_pidx),
      .elem_mask(elem_mask), .zero_mask(zero_mask)
   );

   function automatic logic [12:0] mk(input bit z, input bit inv, input bit fp,
                                      input int dst, input int pidx);
      return {z, inv, fp, dst[4:0], pidx[4:0]};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [XL-1:0] act, input logic [XL-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic write_entry(input int addr, input logic [12:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr[3:0]; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      ref_v[addr] = 1'b1;
      ref_d[addr] = data;
   endtask

   // reference: scan entries in order, the last match (highest index) wins
   task automatic lookup(input string req, input int dst, input bit fp,
                         input logic [XL-1:0] pr);
      logic en = 1'b0, z = 1'b0, inv = 1'b0;
      logic [4:0] pidx = '0;
      logic [XL-1:0] em, zm;
      for (int e = 0; e < NE; e++)
         if (ref_v[e] && ref_d[e][10] == fp && ref_d[e][9:5] == dst[4:0]) begin
            en = 1'b1; z = ref_d[e][12]; inv = ref_d[e][11]; pidx = ref_d[e][4:0];
         end
      em = !en ? {XL{1'b1}} : (inv ? ~pr : pr);
      zm = (en && z) ? ~em : '0;
      lk_dst = dst[4:0]; lk_fp = fp; pred_reg = pr;
      #1;
      chk(req, "enabled", XL'(lk_enabled), XL'(en));
      chk(req, "flags",   XL'({lk_zero, lk_inv, lk_pidx}), XL'({z, inv, pidx}));
      chk(req, "elem_mask", elem_mask, em);
      chk(req, "zero_mask", zero_mask, zm);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [XL-1:0] pat;
      void'($urandom(32'd4676));
      for (int e = 0; e < NE; e++) begin ref_v[e] = 1'b0; ref_d[e] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R4: empty table after reset
      lookup("R1", 0, 0, 64'h0);
      lookup("R1", 3, 1, 64'h1234);
      lookup("R4", 31, 0, 64'hFFFF_0000_5555_AAAA);

      // R2 / R3 / R5: integer entry, plain predicate
      pat = 64'hA5A5_0F0F_3C3C_9696;
      write_entry(0, mk(0, 0, 0, 3, 7));
      lookup("R3", 3, 0, pat);
      lookup("R5", 3, 0, 64'h0);
      lookup("R3", 3, 1, pat);

      // R6 / R7: floating-point entry on the same index, inverted and zeroing
      write_entry(1, mk(1, 1, 1, 3, 9));
      lookup("R6", 3, 1, pat);
      lookup("R7", 3, 1, 64'hFFFF_FFFF_0000_0001);
      lookup("R3", 3, 0, pat);
      write_entry(4, mk(1, 0, 0, 12, 2));
      lookup("R7", 12, 0, 64'h00FF_00FF_00FF_00FF);

      // R8: collisions on integer 3
      write_entry(5, mk(1, 0, 0, 3, 20));
      write_entry(2, mk(0, 1, 0, 3, 1));
      lookup("R8", 3, 0, pat);

      // R9: moving entry 5 away hands the slot to entry 2, freeing entry 4's slot
      write_entry(5, mk(0, 0, 0, 10, 11));
      lookup("R9", 3, 0, pat);
      lookup("R9", 10, 0, pat);
      write_entry(4, mk(0, 0, 1, 30, 0));
      lookup("R9", 12, 0, pat);
      lookup("R9", 30, 1, pat);

      // random mix with forced collisions
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(0, 2) == 0) begin
            int dst = ($urandom_range(0, 3) != 0) ? $urandom_range(0, 7) : $urandom_range(0, 31);
            write_entry($urandom_range(0, NE - 1),
                        mk($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                           dst, $urandom_range(0, 31)));
         end else begin
            @(negedge clk);
            lookup("R8", ($urandom_range(0, 1) != 0) ? $urandom_range(0, 7) : $urandom_range(0, 31),
                   $urandom_range(0, 1), {$urandom(), $urandom()});
         end
      end

      // R1: reset again clears everything
      @(negedge clk);
      rst_n = 1'b0;
      for (int e = 0; e < NE; e++) ref_v[e] = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int d = 0; d < 8; d++) lookup("R1", d, d[0], 64'h0F0F);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule